// File: doc/BRIEF.md
# Battery-Domain Wake Input Conditioner

This block takes a small group of wake pins that stay alive on the battery rail. It turns each of them into a clean, qualified wake condition. Every pin is brought into the clock domain by a two-flop synchroniser. It then passes through an optional stability filter, a per-pin polarity selection and a per-pin enable. After that it feeds a sticky latch and a pair of edge flags, one for rising and one for falling. An override pin and two alarm bits, a weekly alarm and a real-time alarm, are reported next to the pins in a single status word.

One output pin, `wake_out`, is registered. It either reflects the OR of all enabled, conditioned pins, or it carries a value that firmware writes. The choice between the two can be changed at any time through a control bit. Firmware reaches the block through a plain register port. A write takes effect at the clock edge on which `wr_en` is sampled. A read is requested with `rd_en` and answered one cycle later with `rd_valid` and `rd_data`. The port has no back-pressure: every request is served, and the responses come back in order.

Top module: `wake_ctrl`

## Requirements
- R1: The status word (address 0) reports the pin states in bits 6:0, the synchronised override pin in bit 8, `wake_out` in bit 9, the weekly alarm in bit 16 and the real-time alarm in bit 17. Every other bit reads 0.
- R2: Each pin's status bit is 0 while the pin is disabled. Otherwise it shows the pin's latch when that pin's bit in the latch-enable register (address 2) is 1, and the live conditioned level when that bit is 0.
- R3: The polarity register (address 5) resets to all ones. A polarity bit of 1 makes the pin active high and 0 makes it active low. A write updates only the bits whose mask bit in `wr_data[22:16]` is 1, taking the new values from `wr_data[6:0]`.
- R4: Control bit 0 (address 1) is the filter bypass. At 0, a synchronised pin level is accepted only after it has stayed at its new value for 4 consecutive clocks, so a 2-clock pulse is dropped. At 1, the synchronised level is used directly.
- R5: The latch of an enabled, latch-enabled pin sets when the pin is active and holds until a 1 is written to that pin's bit at the latch-clear address (3). If the pin is still active when the latch is cleared, the latch sets again on the next clock.
- R6: A write to the input-enable register (address 4) also clears the latch of every pin whose bit is 1 in the written value.
- R7: Rising flags (address 6) and falling flags (address 7) are separate. They are set only for enabled pins and are cleared by writing a 1. When a flag is set and cleared in the same cycle, the set wins.
- R8: When control bit 2 is 1, `wake_out` takes control bit 1. When control bit 2 is 0, `wake_out` is the OR over enabled pins of the latch (where latching is enabled) or the live level, and control bit 1 has no effect. The output is registered, so it follows one clock later.
- R9: A read with `rd_en` returns `rd_valid` high one clock later, with the data of the addressed register.
- R10: After reset, the status word, control, input-enable, latch-enable and edge flags all read 0, and `wake_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_pin | input | 7 | Raw wake pins |
| ovrd_pin | input | 1 | Raw override pin |
| week_alarm | input | 1 | Weekly alarm flag |
| rtc_alarm | input | 1 | Real-time alarm flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 3 | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 32 | Read data |
| wake_out | output | 1 | Wake output pin |

## Verification
The case that needs care is a rising edge that reaches the flag register in the same cycle as firmware writes 1 to clear that flag. The bench raises a pin with the filter bypassed and counts the two synchroniser stages. It then presents the clear write exactly on the clock edge where the rising flag gets set. It expects the flag to read back as 1. A second collision is a latch clear while the pin is still active: the latch must read 1 again right after the clear.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_LATEN  = 3'd2;
  localparam logic [ADDR_W-1:0] A_LCLR   = 3'd3;
  localparam logic [ADDR_W-1:0] A_INEN   = 3'd4;
  localparam logic [ADDR_W-1:0] A_POL    = 3'd5;
  localparam logic [ADDR_W-1:0] A_RISE   = 3'd6;
  localparam logic [ADDR_W-1:0] A_FALL   = 3'd7;
  // control register bit positions
  localparam int unsigned C_BYPASS = 0;
  localparam int unsigned C_FWVAL  = 1;
  localparam int unsigned C_SRC    = 2;
  // status word positions
  localparam int unsigned S_OVRD = 8;
  localparam int unsigned S_OUT  = 9;
  localparam int unsigned S_WEEK = 16;
  localparam int unsigned S_RTC  = 17;
  localparam int unsigned POL_MASK_LSB = 16;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wake_filter.sv
module wake_filter #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass,
  input  logic d,
  output logic q
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic          level;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (d == level) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      level <= d;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign q = bypass ? d : level;
endmodule

// File: rtl/wake_track.sv
module wake_track (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lat_en,
  input  logic act,
  input  logic lat_clr,
  input  logic rise_clr,
  input  logic fall_clr,
  output logic lat_q,
  output logic rise_q,
  output logic fall_q
);
  logic act_d;
  logic rise_set, fall_set;

  assign rise_set = en &  act & ~act_d;
  assign fall_set = en & ~act &  act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_d  <= 1'b0;
      lat_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      act_d  <= act;
      lat_q  <= lat_clr ? 1'b0 : (lat_q | (en & lat_en & act));
      rise_q <= (rise_q & ~rise_clr) | rise_set;
      fall_q <= (fall_q & ~fall_clr) | fall_set;
    end
  end
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int unsigned NPIN     = 7,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SYNC_LEN = 2,
  parameter int unsigned FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   wake_pin,
  input  logic              ovrd_pin,
  input  logic              week_alarm,
  input  logic              rtc_alarm,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              wake_out
);
  localparam int unsigned CTRL_W = 3;

  logic [NPIN-1:0]   pin_s, pin_f, act, eff;
  logic              ovrd_s;
  logic [CTRL_W-1:0] ctrl_q;
  logic [NPIN-1:0]   inen_q, laten_q, pol_q;
  logic [NPIN-1:0]   latch_q, rise_q, fall_q;
  logic [NPIN-1:0]   lat_clr, rise_clr, fall_clr, pol_msk;
  logic [DATA_W-1:0] status_w;

  wake_sync #(.W(NPIN + 1), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ovrd_pin, wake_pin}), .q({ovrd_s, pin_s})
  );

  // decode of write strobes
  always_comb begin
    lat_clr  = '0;
    rise_clr = '0;
    fall_clr = '0;
    pol_msk  = '0;
    if (wr_en) begin
      if (wr_addr == A_LCLR || wr_addr == A_INEN) lat_clr = wr_data[NPIN-1:0];
      if (wr_addr == A_RISE) rise_clr = wr_data[NPIN-1:0];
      if (wr_addr == A_FALL) fall_clr = wr_data[NPIN-1:0];
      if (wr_addr == A_POL)  pol_msk  = wr_data[POL_MASK_LSB +: NPIN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      inen_q  <= '0;
      laten_q <= '0;
      pol_q   <= '1;
    end else begin
      if (wr_en && wr_addr == A_CTRL)  ctrl_q  <= wr_data[CTRL_W-1:0];
      if (wr_en && wr_addr == A_INEN)  inen_q  <= wr_data[NPIN-1:0];
      if (wr_en && wr_addr == A_LATEN) laten_q <= wr_data[NPIN-1:0];
      pol_q <= (pol_q & ~pol_msk) | (wr_data[NPIN-1:0] & pol_msk);
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    wake_filter #(.LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .bypass(ctrl_q[C_BYPASS]),
      .d(pin_s[g]), .q(pin_f[g])
    );
    assign act[g] = pol_q[g] ? pin_f[g] : ~pin_f[g];
    wake_track u_trk (
      .clk(clk), .rst_n(rst_n), .en(inen_q[g]), .lat_en(laten_q[g]),
      .act(act[g]), .lat_clr(lat_clr[g]), .rise_clr(rise_clr[g]),
      .fall_clr(fall_clr[g]), .lat_q(latch_q[g]), .rise_q(rise_q[g]),
      .fall_q(fall_q[g])
    );
    assign eff[g] = inen_q[g] & (laten_q[g] ? latch_q[g] : act[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_out <= 1'b0;
    else        wake_out <= ctrl_q[C_SRC] ? ctrl_q[C_FWVAL] : (|eff);
  end

  always_comb begin
    status_w             = '0;
    status_w[NPIN-1:0]   = eff;
    status_w[S_OVRD]     = ovrd_s;
    status_w[S_OUT]      = wake_out;
    status_w[S_WEEK]     = week_alarm;
    status_w[S_RTC]      = rtc_alarm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= '0;
        unique case (rd_addr)
          A_STATUS: rd_data <= status_w;
          A_CTRL:   rd_data[CTRL_W-1:0] <= ctrl_q;
          A_LATEN:  rd_data[NPIN-1:0]   <= laten_q;
          A_LCLR:   rd_data <= '0;
          A_INEN:   rd_data[NPIN-1:0]   <= inen_q;
          A_POL:    rd_data[NPIN-1:0]   <= pol_q;
          A_RISE:   rd_data[NPIN-1:0]   <= rise_q;
          A_FALL:   rd_data[NPIN-1:0]   <= fall_q;
          default:  rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/wake_ctrl_chk.sv
module wake_ctrl_chk
  import wake_pkg::*;
#(
  parameter int unsigned NPIN   = 7,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic              rd_valid,
  input logic              wake_out,
  input logic [2:0]        ctrl_q,
  input logic [NPIN-1:0]   pol_q,
  input logic [NPIN-1:0]   latch_q,
  input logic [NPIN-1:0]   rise_q
);
  p_pol_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_POL && !wr_data[POL_MASK_LSB]) |=> $stable(pol_q[0]));

  p_latch_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_LCLR && wr_data[0]) |=> !latch_q[0]);

  p_inen_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_INEN && wr_data[0]) |=> !latch_q[0]);

  p_rise_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_q[0] && !(wr_en && wr_addr == A_RISE && wr_data[0])) |=> rise_q[0]);

  p_fw_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[C_SRC] |=> (wake_out == $past(ctrl_q[C_FWVAL])));

  p_read_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

bind wake_ctrl wake_ctrl_chk #(.NPIN(NPIN), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_en(rd_en), .rd_valid(rd_valid),
  .wake_out(wake_out), .ctrl_q(ctrl_q), .pol_q(pol_q),
  .latch_q(latch_q), .rise_q(rise_q)
);

// File: tb/test_wake_ctrl.sv
module test_wake_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  wake_pin = '0;
  logic        ovrd_pin = 1'b0, week_alarm = 1'b0, rtc_alarm = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_valid, wake_out;
  logic [31:0] rd_data;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  logic [31:0] msk_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  wake_ctrl i_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .wake_pin(wake_pin), .ovrd_pin(ovrd_pin),
    .week_alarm(week_alarm), .rtc_alarm(rtc_alarm), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .wake_out(wake_out)
  );

  // monitor: pops expected read results and compares
  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R9 unexpected read response act=%h exp=none", rd_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic logic [31:0] m = msk_q.pop_front();
        automatic string t = tag_q.pop_front();
        if ((rd_data & m) !== (e & m)) begin
          failures++;
          $display("FAIL %s act=%h exp=%h", t, rd_data & m, e & m);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e,
                    input logic [31:0] m, input string t);
    @(negedge clk);
    exp_q.push_back(e); msk_q.push_back(m); tag_q.push_back(t);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_out(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (wake_out !== e) begin
      failures++;
      $display("FAIL %s wake_out act=%b exp=%b", t, wake_out, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(2);
    // R10 reset state
    rd(3'd0, 32'h0, 32'hFFFF_FFFF, "R10 status after reset");
    rd(3'd1, 32'h0, 32'hFFFF_FFFF, "R10 ctrl after reset");
    rd(3'd4, 32'h0, 32'hFFFF_FFFF, "R10 input enable after reset");
    rd(3'd5, 32'h7F, 32'hFFFF_FFFF, "R3 polarity reset all ones");
    chk_out(1'b0, "R10");
    // R1 status layout
    ovrd_pin = 1; week_alarm = 1; rtc_alarm = 1; idle(5);
    rd(3'd0, 32'h0003_0100, 32'hFFFF_FFFF, "R1 status layout");
    ovrd_pin = 0; week_alarm = 0; rtc_alarm = 0;
    // R2 live level, filter bypassed
    wr(3'd1, 32'h1); wr(3'd4, 32'h7F);
    wake_pin = 7'h05; idle(6);
    rd(3'd0, 32'h05, 32'h7F, "R2 live pins");
    rd(3'd0, 32'h200, 32'h200, "R1 output bit in status");
    chk_out(1'b1, "R8 OR of inputs");
    // R3 polarity with mask
    wr(3'd5, 32'h0001_0000);
    rd(3'd5, 32'h7E, 32'hFFFF_FFFF, "R3 masked polarity write");
    idle(4);
    rd(3'd0, 32'h04, 32'h7F, "R3 active-low pin inactive");
    wr(3'd5, 32'h0000_0000);
    rd(3'd5, 32'h7E, 32'hFFFF_FFFF, "R3 zero mask leaves polarity");
    wr(3'd5, 32'h0001_0001);
    // R7 edge flags
    wake_pin = 7'h00; idle(6);
    wr(3'd6, 32'h7F); wr(3'd7, 32'h7F);
    rd(3'd6, 32'h0, 32'hFFFF_FFFF, "R7 rise cleared");
    rd(3'd7, 32'h0, 32'hFFFF_FFFF, "R7 fall cleared");
    wake_pin[3] = 1; idle(6);
    rd(3'd6, 32'h08, 32'hFFFF_FFFF, "R7 rise flag");
    rd(3'd7, 32'h00, 32'hFFFF_FFFF, "R7 no fall on rise");
    wake_pin[3] = 0; idle(6);
    rd(3'd7, 32'h08, 32'hFFFF_FFFF, "R7 fall flag");
    wr(3'd6, 32'h08);
    rd(3'd6, 32'h00, 32'hFFFF_FFFF, "R7 rise write-one-clear");
    wr(3'd4, 32'h6F);
    wake_pin[4] = 1; idle(6); wake_pin[4] = 0; idle(6);
    rd(3'd6, 32'h00, 32'hFFFF_FFFF, "R7 disabled pin no rise");
    rd(3'd7, 32'h08, 32'hFFFF_FFFF, "R7 disabled pin no fall");
    wr(3'd4, 32'h7F);
    // R7 set and clear in the same cycle: set wins
    @(negedge clk); wake_pin[1] = 1;
    @(negedge clk);
    @(negedge clk); wr_en = 1; wr_addr = 3'd6; wr_data = 32'h02;
    @(negedge clk); wr_en = 0;
    rd(3'd6, 32'h02, 32'hFFFF_FFFF, "R7 set wins over clear");
    wr(3'd6, 32'h02);
    rd(3'd6, 32'h00, 32'hFFFF_FFFF, "R7 clear after collision");
    // R5 latch
    wake_pin = 7'h00; idle(6);
    wr(3'd2, 32'h02); wr(3'd3, 32'h7F);
    rd(3'd0, 32'h00, 32'h7F, "R5 latch cleared");
    wake_pin[1] = 1; idle(6); wake_pin[1] = 0; idle(6);
    rd(3'd0, 32'h02, 32'h7F, "R5 latch holds");
    wr(3'd3, 32'h02);
    rd(3'd0, 32'h00, 32'h7F, "R5 latch clear");
    wake_pin[1] = 1; idle(6);
    wr(3'd3, 32'h02);
    rd(3'd0, 32'h02, 32'h7F, "R5 latch resets while active");
    rd(3'd2, 32'h02, 32'hFFFF_FFFF, "R9 latch enable readback");
    // R6 input enable write clears latches
    wake_pin[1] = 0; idle(6);
    rd(3'd0, 32'h02, 32'h7F, "R6 latch held before enable write");
    wr(3'd4, 32'h7F);
    rd(3'd0, 32'h00, 32'h7F, "R6 enable write clears latch");
    // R4 filter
    wr(3'd2, 32'h22); wr(3'd1, 32'h0);
    @(negedge clk); wake_pin[5] = 1; idle(2); wake_pin[5] = 0; idle(10);
    rd(3'd0, 32'h00, 32'h20, "R4 short pulse filtered");
    wake_pin[5] = 1; idle(8); wake_pin[5] = 0; idle(10);
    rd(3'd0, 32'h20, 32'h20, "R4 long pulse accepted");
    wr(3'd3, 32'h20); wr(3'd1, 32'h1);
    @(negedge clk); wake_pin[5] = 1; idle(2); wake_pin[5] = 0; idle(10);
    rd(3'd0, 32'h20, 32'h20, "R4 bypass passes short pulse");
    // R8 output selection
    wr(3'd2, 32'h00); wr(3'd3, 32'h7F); idle(3);
    chk_out(1'b0, "R8 no active inputs");
    wr(3'd1, 32'h3); idle(2);
    chk_out(1'b0, "R8 firmware bit ignored when input driven");
    wake_pin[0] = 1; wr(3'd1, 32'h5); idle(6);
    chk_out(1'b0, "R8 firmware drives 0");
    wr(3'd1, 32'h7); idle(1);
    chk_out(1'b1, "R8 firmware drives 1");
    rd(3'd0, 32'h200, 32'h200, "R8 status output bit");
    wr(3'd1, 32'h1); idle(1);
    chk_out(1'b1, "R8 back to inputs");
    wr(3'd2, 32'h01); idle(2); wake_pin[0] = 0; idle(6);
    chk_out(1'b1, "R8 latched input holds output");
    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule